// File: doc/BRIEF.md
# Display Layer Compositor with Color Key

The block draws one display frame after another as a raster of 24-bit pixels. Every position of a programmable work area gets the background color unless it falls inside a rectangular layer window. Inside that window the colors come from a stream of 32-bit words, each carrying two 16-bit 5-6-5 pixels.

Before a pixel is taken from a word, the four bytes of the word may be reordered. The 5- and 6-bit channels are widened to 8 bits by repeating their top bits. A pixel that matches the key value is replaced by the background. Otherwise it is mixed with the background using one alpha value that holds for the whole layer.

An ordered 2x2 dither can prepare the output for a panel with 6 bits per channel. The raster stalls for as long as it sits inside the window and no word is offered, and every pixel leaves the block two clock cycles after its raster step.

Top module: `osd_compositor`

## Requirements
- R1: While `rst_n` is low, `outValid`, `outSof` and `outEol` are low. After release the raster starts at column 0, row 0.
- R2: The raster emits one pixel per raster step, row by row, left to right. `outSof` marks the pixel at (0,0) and `outEol` marks column width-1. Work width sits in bits [11:0] of `workSize` and height in bits [27:16]. `layerSize` and `layerPos` pack width/X and height/Y the same way.
- R3: A pixel outside the layer window shows `bgColor[23:0]`, with red in [23:16], green in [15:8] and blue in [7:0].
- R4: `byteOrder` rearranges the word, where Bn is bits [8n+7:8n]. The rearranged word, written from bit 31 down, is: 0 = B3 B2 B1 B0, 1 = B0 B1 B2 B3, 2 = B2 B3 B0 B1, 3 = B1 B0 B3 B2. The first pixel of a word is taken from bits [15:0] of the result and the second from [31:16].
- R5: `pixInReady` is high inside the window when the current pixel is the second of its word, or when it is the last column of the layer. A word popped at the last column of an odd-width row has its upper half discarded, and each layer row starts on a fresh word.
- R6: Inside the window with `pixInValid` low, the raster holds its position and no pixel is emitted for that cycle.
- R7: A 5-6-5 pixel holds red in [15:11], green in [10:5] and blue in [4:0]. Each channel widens to 8 bits by repeating its most significant bits below itself.
- R8: With `ckEn` high, a layer pixel whose raw 16-bit value equals `ckValue` shows the background.
- R9: Each channel of a layer pixel is (a*L + (255-a)*B + 128) >> 8, where a is `alpha`, L the widened layer value and B the background. When `alpha` is 0xFF the result is exactly L.
- R10: With `ditherEn` high, each channel c becomes min(c+t, 255) with its two low bits cleared. The threshold t is 0, 2, 3 and 1 at (x even, y even), (x odd, y even), (x even, y odd) and (x odd, y odd).
- R11: A pixel appears on the outputs exactly two clock cycles after its raster step.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bgColor | input | 32 | Background color, RGB in bits [23:0] |
| alpha | input | 8 | Layer-wide alpha |
| ckEn | input | 1 | Color key enable |
| ckValue | input | 16 | Raw 5-6-5 key value |
| byteOrder | input | 2 | Byte rearrangement code |
| ditherEn | input | 1 | Ordered dither enable |
| workSize | input | 32 | Work area width [11:0], height [27:16] |
| layerSize | input | 32 | Layer width [11:0], height [27:16] |
| layerPos | input | 32 | Layer X [11:0], Y [27:16] |
| pixIn | input | 32 | Two packed 5-6-5 pixels |
| pixInValid | input | 1 | Word offered |
| pixInReady | output | 1 | Word consumed this cycle when valid |
| outValid | output | 1 | Output pixel present |
| outRgb | output | 24 | Output color |
| outSof | output | 1 | First pixel of frame |
| outEol | output | 1 | Last pixel of row |

## Verification
The hardest case to reach from the ports is a word pop at the last column of an odd-width layer row, especially when that pop coincides with a stall or with a window that touches the work-area corner. The stimulus uses odd layer widths and a 1x1 layer in the bottom-right corner, and it drops `pixInValid` in random cycles. A behavioural reference model tracks the raster and the word queue and is compared against the design on every clock.

// File: rtl/osd_pkg.sv
package osd_pkg;
  typedef struct packed {
    logic adv;      // raster steps this cycle
    logic inWin;    // position inside layer window
    logic useHigh;  // take upper half of word
    logic sof;
    logic eol;
    logic xLsb;
    logic yLsb;
  } osd_strobe_t;
endpackage

// File: rtl/osd_raster_ctrl.sv
module osd_raster_ctrl
  import osd_pkg::*;
#(
  parameter int COORD_W = 12
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [31:0] workSize,
  input  logic [31:0] layerSize,
  input  logic [31:0] layerPos,
  input  logic        pixInValid,
  output logic        pixInReady,
  output osd_strobe_t strb
);
  localparam int SUM_W = COORD_W + 1;

  logic [COORD_W-1:0] xPos, yPos;
  logic               phase;
  logic [COORD_W-1:0] workW, workH;
  logic [SUM_W-1:0]   winX0, winX1, winY0, winY1, xExt, yExt;
  logic               inWin, lastCol, xLast, yLast, adv;

  assign workW = workSize[COORD_W-1:0];
  assign workH = workSize[16 +: COORD_W];
  assign winX0 = {1'b0, layerPos[COORD_W-1:0]};
  assign winY0 = {1'b0, layerPos[16 +: COORD_W]};
  assign winX1 = winX0 + {1'b0, layerSize[COORD_W-1:0]};
  assign winY1 = winY0 + {1'b0, layerSize[16 +: COORD_W]};
  assign xExt  = {1'b0, xPos};
  assign yExt  = {1'b0, yPos};

  assign inWin   = (xExt >= winX0) && (xExt < winX1) && (yExt >= winY0) && (yExt < winY1);
  assign lastCol = (xExt == (winX1 - SUM_W'(1)));
  assign xLast   = (xPos == (workW - COORD_W'(1)));
  assign yLast   = (yPos == (workH - COORD_W'(1)));
  assign adv     = !(inWin && !pixInValid);

  assign pixInReady = inWin && (phase || lastCol);

  always_comb begin
    strb.adv     = adv;
    strb.inWin   = inWin;
    strb.useHigh = phase;
    strb.sof     = (xPos == '0) && (yPos == '0);
    strb.eol     = xLast;
    strb.xLsb    = xPos[0];
    strb.yLsb    = yPos[0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      xPos  <= '0;
      yPos  <= '0;
      phase <= 1'b0;
    end else if (adv) begin
      phase <= inWin && !lastCol && !phase;
      if (xLast) begin
        xPos <= '0;
        yPos <= yLast ? '0 : yPos + COORD_W'(1);
      end else begin
        xPos <= xPos + COORD_W'(1);
      end
    end
  end

  // R6
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (inWin && !pixInValid) |=> ($stable(xPos) && $stable(yPos) && $stable(phase)));

  // R5
  pop_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pixInValid && pixInReady) |=> !phase);

  // R2
  x_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $stable(workSize) |-> (xPos < workW));
endmodule

// File: rtl/osd_pixel_path.sv
module osd_pixel_path
  import osd_pkg::*;
#(
  parameter int CH_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  osd_strobe_t       strb,
  input  logic [31:0]       pixIn,
  input  logic [1:0]        byteOrder,
  input  logic              ckEn,
  input  logic [15:0]       ckValue,
  input  logic [31:0]       bgColor,
  input  logic [CH_W-1:0]   alpha,
  input  logic              ditherEn,
  output logic              outValid,
  output logic [3*CH_W-1:0] outRgb,
  output logic              outSof,
  output logic              outEol
);
  localparam int RGB_W  = 3 * CH_W;
  localparam int PROD_W = 2 * CH_W;
  localparam logic [CH_W-1:0] FULL = '1;

  logic [31:0]      ordWord;
  logic [15:0]      pix;
  logic [RGB_W-1:0] layerWide;
  logic             keyHit;

  always_comb begin
    case (byteOrder)
      2'd1:    ordWord = {pixIn[7:0],   pixIn[15:8],  pixIn[23:16], pixIn[31:24]};
      2'd2:    ordWord = {pixIn[23:16], pixIn[31:24], pixIn[7:0],   pixIn[15:8]};
      2'd3:    ordWord = {pixIn[15:8],  pixIn[7:0],   pixIn[31:24], pixIn[23:16]};
      default: ordWord = pixIn;
    endcase
  end

  assign pix       = strb.useHigh ? ordWord[31:16] : ordWord[15:0];
  assign layerWide = {pix[15:11], pix[15:13], pix[10:5], pix[10:9], pix[4:0], pix[4:2]};
  assign keyHit    = ckEn && (pix == ckValue);

  logic             s1Valid, s1Sof, s1Eol, s1UseLayer, s1Xl, s1Yl;
  logic [RGB_W-1:0] s1Layer;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1Valid    <= 1'b0;
      s1Sof      <= 1'b0;
      s1Eol      <= 1'b0;
      s1UseLayer <= 1'b0;
      s1Xl       <= 1'b0;
      s1Yl       <= 1'b0;
      s1Layer    <= '0;
    end else begin
      s1Valid    <= strb.adv;
      s1Sof      <= strb.adv && strb.sof;
      s1Eol      <= strb.adv && strb.eol;
      s1UseLayer <= strb.inWin && !keyHit;
      s1Xl       <= strb.xLsb;
      s1Yl       <= strb.yLsb;
      s1Layer    <= layerWide;
    end
  end

  logic [1:0]       thr;
  logic [RGB_W-1:0] mixRgb;
  assign thr = {s1Xl ^ s1Yl, s1Yl};

  for (genvar ch = 0; ch < 3; ch++) begin : g_chan
    logic [CH_W-1:0]   lay, bg, chosen, sat, blended;
    logic [PROD_W-1:0] mix;
    logic [CH_W:0]     dsum;
    assign lay = s1Layer[ch*CH_W +: CH_W];
    assign bg  = bgColor[ch*CH_W +: CH_W];
    assign mix = PROD_W'(alpha) * PROD_W'(lay)
               + PROD_W'(FULL - alpha) * PROD_W'(bg)
               + PROD_W'(1 << (CH_W - 1));
    assign blended = (alpha == FULL) ? lay : mix[PROD_W-1:CH_W];
    assign chosen  = s1UseLayer ? blended : bg;
    assign dsum    = {1'b0, chosen} + (CH_W+1)'(thr);
    assign sat     = dsum[CH_W] ? FULL : dsum[CH_W-1:0];
    assign mixRgb[ch*CH_W +: CH_W] = ditherEn ? {sat[CH_W-1:2], 2'b00} : chosen;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      outValid <= 1'b0;
      outSof   <= 1'b0;
      outEol   <= 1'b0;
      outRgb   <= '0;
    end else begin
      outValid <= s1Valid;
      outSof   <= s1Sof;
      outEol   <= s1Eol;
      outRgb   <= mixRgb;
    end
  end

  // R11
  latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
    strb.adv |-> ##2 outValid);

  // R2
  sof_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (outSof || outEol) |-> outValid);

  // R9
  full_alpha_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (s1Valid && s1UseLayer && alpha == FULL && !ditherEn && $stable(alpha) && $stable(ditherEn))
      |=> (outRgb == $past(s1Layer)));
endmodule

// File: rtl/osd_compositor.sv
module osd_compositor
  import osd_pkg::*;
#(
  parameter int COORD_W = 12,
  parameter int CH_W    = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [31:0]       bgColor,
  input  logic [CH_W-1:0]   alpha,
  input  logic              ckEn,
  input  logic [15:0]       ckValue,
  input  logic [1:0]        byteOrder,
  input  logic              ditherEn,
  input  logic [31:0]       workSize,
  input  logic [31:0]       layerSize,
  input  logic [31:0]       layerPos,
  input  logic [31:0]       pixIn,
  input  logic              pixInValid,
  output logic              pixInReady,
  output logic              outValid,
  output logic [3*CH_W-1:0] outRgb,
  output logic              outSof,
  output logic              outEol
);
  osd_strobe_t strb;

  osd_raster_ctrl #(.COORD_W(COORD_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .workSize(workSize), .layerSize(layerSize),
    .layerPos(layerPos), .pixInValid(pixInValid), .pixInReady(pixInReady), .strb(strb)
  );

  osd_pixel_path #(.CH_W(CH_W)) u_path (
    .clk(clk), .rst_n(rst_n), .strb(strb), .pixIn(pixIn), .byteOrder(byteOrder),
    .ckEn(ckEn), .ckValue(ckValue), .bgColor(bgColor), .alpha(alpha),
    .ditherEn(ditherEn), .outValid(outValid), .outRgb(outRgb),
    .outSof(outSof), .outEol(outEol)
  );

  // R1
  reset_quiet_chk: assert property (@(posedge clk)
    !rst_n |=> (!outValid || $past(rst_n)));
endmodule

// File: tb/tb_osd_compositor.sv
`timescale 1ns/1ps
module tb_osd_compositor;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] bgColor = 32'hFFFFFFFF;
  logic [7:0]  alpha = 8'hFF;
  logic        ckEn = 1'b0;
  logic [15:0] ckValue = 16'h0;
  logic [1:0]  byteOrder = 2'd0;
  logic        ditherEn = 1'b0;
  logic [31:0] workSize = 32'h0, layerSize = 32'h0, layerPos = 32'h0;
  logic [31:0] pixIn = 32'h0;
  logic        pixInValid = 1'b0;
  logic        pixInReady, outValid, outSof, outEol;
  logic [23:0] outRgb;

  always #2.5 clk = ~clk;

  osd_compositor dut (
    .clk(clk), .rst_n(rst_n), .bgColor(bgColor), .alpha(alpha), .ckEn(ckEn),
    .ckValue(ckValue), .byteOrder(byteOrder), .ditherEn(ditherEn),
    .workSize(workSize), .layerSize(layerSize), .layerPos(layerPos),
    .pixIn(pixIn), .pixInValid(pixInValid), .pixInReady(pixInReady),
    .outValid(outValid), .outRgb(outRgb), .outSof(outSof), .outEol(outEol)
  );

  int checks = 0, failures = 0;
  bit done = 0;

  task automatic chk(input bit ok, input string tag, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=0x%0h expected=0x%0h at %0t", tag, what, act, exp, $time);
    end
  endtask

  // reference model state
  int ww, wh, lw, lh, px, py, mx, my, mph;
  logic [31:0] wq[$];
  bit m1v, m2v, m1s, m2s, m1e, m2e;
  int m1c, m2c;
  string m1t, m2t;

  function automatic int expandPix(input int p);
    int r, g, b;
    r = (p >> 11) & 31; g = (p >> 5) & 63; b = p & 31;
    return ((((r << 3) | (r >> 2))) << 16) | ((((g << 2) | (g >> 4))) << 8) | ((b << 3) | (b >> 2));
  endfunction

  function automatic int mixOne(input int a, input int l, input int b);
    if (a == 255) return l;
    return (a * l + (255 - a) * b + 128) / 256;
  endfunction

  function automatic int ditherOne(input int c, input int x, input int y);
    int t, s;
    if (y % 2 == 0) t = (x % 2 == 0) ? 0 : 2;
    else            t = (x % 2 == 0) ? 3 : 1;
    s = c + t;
    if (s > 255) s = 255;
    return s & 252;
  endfunction

  function automatic int pickHalf(input logic [31:0] w, input int ord, input int hi);
    logic [7:0] bt[4];
    logic [31:0] r;
    for (int i = 0; i < 4; i++) bt[i] = w[8*i +: 8];
    case (ord)
      1: r = {bt[0], bt[1], bt[2], bt[3]};
      2: r = {bt[2], bt[3], bt[0], bt[1]};
      3: r = {bt[1], bt[0], bt[3], bt[2]};
      default: r = w;
    endcase
    return hi ? int'(r[31:16]) : int'(r[15:0]);
  endfunction

  function automatic logic [31:0] newWord();
    logic [31:0] w;
    w = $urandom;
    if ($urandom % 3 == 0) w[15:0] = ckValue;
    if ($urandom % 3 == 0) w[31:16] = ckValue;
    return w;
  endfunction

  task automatic runScenario(input int w_, input int h_, input int lw_, input int lh_,
                             input int px_, input int py_, input int ord, input int a,
                             input bit ck, input bit dth, input logic [31:0] bg, input int cycles);
    @(negedge clk);
    rst_n = 1'b0;
    workSize = (h_ << 16) | w_; layerSize = (lh_ << 16) | lw_; layerPos = (py_ << 16) | px_;
    byteOrder = ord[1:0]; alpha = a[7:0]; ckEn = ck; ditherEn = dth; bgColor = bg;
    ckValue = 16'hF81F; pixInValid = 1'b0;
    ww = w_; wh = h_; lw = lw_; lh = lh_; px = px_; py = py_;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      chk(!outValid && !outSof && !outEol, "R1", "outputs during reset", {outValid, outSof, outEol}, 0);
    end
    mx = 0; my = 0; mph = 0; wq.delete();
    m1v = 0; m2v = 0; m1s = 0; m2s = 0; m1e = 0; m2e = 0; m1c = 0; m2c = 0; m1t = ""; m2t = "";
    rst_n = 1'b1;
    for (int cyc = 0; cyc < cycles; cyc++) begin
      bit inWin, lastCol, rdy, vld;
      int col, pv;
      string tg;
      if (cyc > 0) begin
        @(negedge clk);
        chk(outValid == m2v, "R6 R11", "outValid", outValid, m2v);
        if (m2v) begin
          chk(outRgb == m2c[23:0], m2t, "outRgb", outRgb, m2c);
          chk(outSof == m2s, "R2", "outSof", outSof, m2s);
          chk(outEol == m2e, "R2", "outEol", outEol, m2e);
        end
      end
      inWin = (mx >= px) && (mx < px + lw) && (my >= py) && (my < py + lh);
      lastCol = (mx == px + lw - 1);
      rdy = inWin && (mph != 0 || lastCol);
      chk(pixInReady == rdy, "R5", "pixInReady", pixInReady, rdy);
      while (wq.size() < 4) wq.push_back(newWord());
      vld = ($urandom % 4) != 0;
      pixInValid = vld;
      pixIn = wq[0];
      m2v = m1v; m2c = m1c; m2s = m1s; m2e = m1e; m2t = m1t;
      if (inWin && !vld) begin
        m1v = 0; m1s = 0; m1e = 0;
      end else begin
        m1v = 1;
        m1s = (mx == 0 && my == 0);
        m1e = (mx == ww - 1);
        if (inWin) begin
          pv = pickHalf(wq[0], ord, mph);
          if (ck && pv == int'(ckValue)) begin
            col = bg[23:0]; tg = "R8";
          end else begin
            int l;
            l = expandPix(pv);
            col = (mixOne(a, (l >> 16) & 255, bg[23:16]) << 16) |
                  (mixOne(a, (l >> 8) & 255, bg[15:8]) << 8) |
                   mixOne(a, l & 255, bg[7:0]);
            tg = "R4 R7 R9";
          end
        end else begin
          col = bg[23:0]; tg = "R3";
        end
        if (dth) begin
          col = (ditherOne((col >> 16) & 255, mx, my) << 16) |
                (ditherOne((col >> 8) & 255, mx, my) << 8) |
                 ditherOne(col & 255, mx, my);
          tg = {tg, " R10"};
        end
        m1c = col; m1t = tg;
        if (rdy) void'(wq.pop_front());
        mph = (inWin && !lastCol && mph == 0) ? 1 : 0;
        if (mx == ww - 1) begin
          mx = 0; my = (my == wh - 1) ? 0 : my + 1;
        end else mx++;
      end
    end
  endtask

  initial begin
    runScenario(8, 4, 5, 2, 2, 1, 0, 255, 0, 0, 32'hFF123456, 200);
    runScenario(6, 3, 4, 3, 1, 0, 2, 128, 1, 0, 32'h00A0B0C0, 200);
    runScenario(4, 4, 4, 4, 0, 0, 1, 64,  0, 1, 32'hFFFFFFFF, 200);
    runScenario(5, 3, 1, 1, 4, 2, 3, 255, 1, 1, 32'h00FE01FF, 200);
    runScenario(7, 2, 3, 2, 0, 0, 2, 0,   1, 0, 32'h00102030, 150);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule